// File: doc/BRIEF.md
# Reload-and-Match Timer PWM

This block turns a 32-bit up-counter into a pulse-width modulated output. The counter climbs from a programmable reload value toward all-ones. The tick that finds it at all-ones is the overflow: it puts the reload value back into the counter and drives the output to its active level. Later in the same period, the tick that finds the counter equal to a programmable match value drives the output to its inactive level. The reload value therefore sets the period, and the distance from reload to match sets the active time. Software keeps `reload <= match < 0xFFFFFFFF`.

Software programs the block through a plain write strobe and a read strobe. The addressable locations are control, reload, match, a directly writable counter and a read-only status word. The control word holds a run bit, a polarity bit, a prescaler enable and a 3-bit prescaler exponent. The reload and match registers are not shadowed, so a write while running takes effect at the next reload or compare. The polarity bit is frozen while running. To change it, software stops the timer, writes the new polarity, preloads the counter with 0xFFFFFFFE and starts again. That preload makes the first overflow, and so the first active edge, come right after start.

A waveform state machine tracks the output phase. Its states are IDLE (stopped), ARMED (running, no overflow seen yet), ON (active phase) and OFF (inactive phase). It has these transitions:
- IDLE→ARMED when run is set.
- IDLE→ON when run is set and an overflow happens in the same cycle.
- ARMED/OFF→ON on overflow.
- ARMED/ON→OFF on match.
- any→IDLE when run is cleared.

Top module: `reload_match_pwm`

## Requirements
- R1: After reset, the output is 0. Reads of control, reload, match, counter and status all return 0.
- R2: An overflow loads the reload value into the counter and makes the output active. The active time lasts `match - reload + 1` count ticks.
- R3: The inactive time lasts `0xFFFFFFFF - match` count ticks, so one period is `0xFFFFFFFF - reload + 1` ticks.
- R4: With the prescaler off and the counter preloaded with 0xFFFFFFFE, the output becomes active at the second clock edge after the edge that takes the start write.
- R5: Clearing the run bit stops counting at once. The output goes to its inactive level in the same cycle, and the counter keeps its value while stopped.
- R6: With the polarity bit set, the output is the complement of the normal waveform. While stopped, the output rests at the inactive level of the selected polarity: 1 when inverted, 0 when normal.
- R7: A control write while running leaves the polarity bit unchanged.
- R8: The status word (address 4) returns the run bit in bit 0 and the polarity bit in bit 1.
- R9: With the prescaler enabled, each count tick takes 2^(p+1) clocks, where p is the 3-bit exponent. Phase lengths scale by that ratio.
- R10: The smallest legal settings, reload = match = 0xFFFFFFFE, give one tick active and one tick inactive.
- R11: When overflow and match fall in the same tick (match = 0xFFFFFFFF), overflow wins and the output stays active.
- R12: Reload and match writes during running apply from the next reload or compare, without a restart.

Register addresses:

| Address | Location |
|---|---|
| 0 | control |
| 1 | reload |
| 2 | match |
| 3 | counter |
| 4 | status |

Control word bits:

| Bit | Field |
|---|---|
| 0 | run |
| 1 | polarity |
| 2 | prescaler enable |
| 5:3 | prescaler exponent |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, data valid after the next edge |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pwm_out | output | 1 | PWM waveform |

## Verification
The overflow event and the match event can land on the same count tick. The bench provokes this by programming match to all-ones with a short reload distance. It judges the result by requiring the output to stay active across several full periods, since overflow must take priority. The minimum setting makes the two events fall on consecutive ticks, which checks that neither one swallows the other.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_LOAD  = 3'd1;
    localparam logic [2:0] A_MATCH = 3'd2;
    localparam logic [2:0] A_COUNT = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;

    localparam int CTL_RUN = 0;
    localparam int CTL_INV = 1;
    localparam int CTL_PRE = 2;
    localparam int CTL_PTV = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ON    = 2'd2,
        ST_OFF   = 2'd3
    } wave_state_t;

endpackage

// File: rtl/rmp_regs.sv
module rmp_regs
    import rmp_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             run_o,
    output logic             inv_o,
    output logic             pre_en_o,
    output logic [PTV_W-1:0] ptv_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] match_o,
    output logic             cnt_wr_o,
    output logic [CNT_W-1:0] cnt_wdata_o
);

    localparam int CTL_BITS = CTL_PTV + PTV_W;

    logic             run_q, inv_q, pre_q;
    logic [PTV_W-1:0] ptv_q;
    logic [CNT_W-1:0] load_q, match_q;
    logic [CNT_W-1:0] rd_mux;
    logic [CTL_BITS-1:0] ctl_view;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            inv_q   <= 1'b0;
            pre_q   <= 1'b0;
            ptv_q   <= '0;
            load_q  <= '0;
            match_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    run_q <= reg_wdata[CTL_RUN];
                    pre_q <= reg_wdata[CTL_PRE];
                    ptv_q <= reg_wdata[CTL_PTV +: PTV_W];
                    if (!run_q)
                        inv_q <= reg_wdata[CTL_INV];
                end
                A_LOAD:  load_q  <= reg_wdata;
                A_MATCH: match_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign ctl_view = {ptv_q, pre_q, inv_q, run_q};

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            A_CTRL:  rd_mux[CTL_BITS-1:0] = ctl_view;
            A_LOAD:  rd_mux = load_q;
            A_MATCH: rd_mux = match_q;
            A_COUNT: rd_mux = cnt_i;
            A_STAT:  rd_mux[1:0] = {inv_q, run_q};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    assign run_o       = run_q;
    assign inv_o       = inv_q;
    assign pre_en_o    = pre_q;
    assign ptv_o       = ptv_q;
    assign load_o      = load_q;
    assign match_o     = match_q;
    assign cnt_wr_o    = reg_wr && (reg_addr == A_COUNT);
    assign cnt_wdata_o = reg_wdata;

    // R7: polarity frozen while the timer runs
    p_pol_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && run_q) |=> (inv_q == $past(inv_q)));

endmodule

// File: rtl/rmp_prescale.sv
module rmp_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pre_en_i,
    input  logic [PTV_W-1:0] ptv_i,
    output logic             tick_o
);

    localparam int DIV_W = 1 << PTV_W;

    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] term;
    logic             at_term;

    assign term    = (DIV_W'(1) << (ptv_i + 1)) - DIV_W'(1);
    assign at_term = (pre_cnt == term);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (!run_i || !pre_en_i || at_term)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

    assign tick_o = run_i && (!pre_en_i || at_term);

    // R9: a divided tick never repeats on the next clock
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en_i && tick_o && $stable(ptv_i)) |=> !tick_o);

endmodule

// File: rtl/rmp_counter.sv
module rmp_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] match_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step    = tick_i && !cnt_wr_i;
    assign ovf_o   = step && (cnt_q == ALL1);
    assign match_o = step && (cnt_q == match_i) && (cnt_q != ALL1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr_i)
            cnt_q <= cnt_wdata_i;
        else if (tick_i)
            cnt_q <= (cnt_q == ALL1) ? load_i : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2: overflow reloads the counter
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == $past(load_i)));

    // R5: a counter with no tick and no write keeps its value
    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rmp_wave_fsm.sv
module rmp_wave_fsm
    import rmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic inv_i,
    input  logic ovf_i,
    input  logic match_i,
    output logic pwm_o
);

    wave_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (run_i)
                    nxt = ovf_i ? ST_ON : ST_ARMED;
            end
            ST_ARMED, ST_ON, ST_OFF: begin
                if (!run_i)
                    nxt = ST_IDLE;
                else if (ovf_i)
                    nxt = ST_ON;
                else if (match_i)
                    nxt = ST_OFF;
            end
        endcase
    end

    always_comb begin
        pwm_o = ((state == ST_ON) && run_i) ^ inv_i;
    end

    // R2: an overflow always leads into the active phase
    p_ovf_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> (state == ST_ON));

    // R11: overflow and match are never both raised
    p_evt_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_i && match_i));

endmodule

// File: rtl/reload_match_pwm.sv
module reload_match_pwm #(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             pwm_out
);

    logic             run, inv, pre_en, tick, cnt_wr, ovf, mat;
    logic [PTV_W-1:0] ptv;
    logic [CNT_W-1:0] load, match, cnt, cnt_wdata;

    rmp_regs #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_i(cnt), .run_o(run), .inv_o(inv), .pre_en_o(pre_en),
        .ptv_o(ptv), .load_o(load), .match_o(match),
        .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata)
    );

    rmp_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .pre_en_i(pre_en),
        .ptv_i(ptv), .tick_o(tick)
    );

    rmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_wr_i(cnt_wr),
        .cnt_wdata_i(cnt_wdata), .load_i(load), .match_i(match),
        .cnt_o(cnt), .ovf_o(ovf), .match_o(mat)
    );

    rmp_wave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_i(run), .inv_i(inv),
        .ovf_i(ovf), .match_i(mat), .pwm_o(pwm_out)
    );

    // R5 / R6: a stopped timer rests at the inactive level of its polarity
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == inv));

endmodule

// File: tb/reload_match_pwm_test.sv
module reload_match_pwm_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_match_pwm uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // measure one full period of the active level (act = pwm_out ^ inv_sel)
    task automatic measure(input logic inv_sel, output int hi, output int lo);
        hi = 0; lo = 0;
        for (int g = 0; g < 4000 && ((pwm_out ^ inv_sel) != 1'b0); g++) @(negedge clk);
        for (int g = 0; g < 4000 && ((pwm_out ^ inv_sel) != 1'b1); g++) @(negedge clk);
        while ((pwm_out ^ inv_sel) == 1'b1 && hi < 4000) begin hi++; @(negedge clk); end
        while ((pwm_out ^ inv_sel) == 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 pwm_out", {31'b0, pwm_out}, 32'd0);
        rd(3'd0, d); check("R1 control", d, 32'd0);
        rd(3'd1, d); check("R1 reload", d, 32'd0);
        rd(3'd2, d); check("R1 match", d, 32'd0);
        rd(3'd3, d); check("R1 counter", d, 32'd0);
        rd(3'd4, d); check("R1 status", d, 32'd0);
    endtask

    task automatic t_basic();
        int hi, lo;
        logic [31:0] d;
        wr(3'd1, 32'hFFFF_FFF0);
        wr(3'd2, 32'hFFFF_FFF5);
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd0, 32'd1);
        check("R4 first tick still inactive", {31'b0, pwm_out}, 32'd0);
        @(negedge clk);
        check("R4 after first tick inactive", {31'b0, pwm_out}, 32'd0);
        @(negedge clk);
        check("R4 active after second tick", {31'b0, pwm_out}, 32'd1);
        measure(1'b0, hi, lo);
        check("R2 active length", hi, 32'd6);
        check("R3 inactive length", lo, 32'd10);
        rd(3'd4, d); check("R8 status running", d, 32'd1);
    endtask

    task automatic t_update();
        int hi, lo;
        wr(3'd2, 32'hFFFF_FFF9);
        measure(1'b0, hi, lo);
        check("R12 new match active", hi, 32'd10);
        check("R12 new match inactive", lo, 32'd6);
        wr(3'd1, 32'hFFFF_FFE0);
        measure(1'b0, hi, lo);
        check("R12 new reload active", hi, 32'd26);
        wr(3'd1, 32'hFFFF_FFF0);
        wr(3'd2, 32'hFFFF_FFF5);
        measure(1'b0, hi, lo);
    endtask

    task automatic t_pol_locked();
        int hi, lo;
        logic [31:0] d;
        wr(3'd0, 32'd3);
        rd(3'd4, d); check("R7 polarity kept while running", d, 32'd1);
        measure(1'b0, hi, lo);
        check("R7 waveform unchanged", hi, 32'd6);
    endtask

    task automatic t_stop();
        logic [31:0] c1, c2;
        wr(3'd0, 32'd0);
        check("R5 inactive at once", {31'b0, pwm_out}, 32'd0);
        rd(3'd3, c1);
        repeat (10) @(negedge clk);
        rd(3'd3, c2);
        check("R5 counter held", c2, c1);
        check("R5 still inactive", {31'b0, pwm_out}, 32'd0);
    endtask

    task automatic t_invert();
        int hi, lo;
        logic [31:0] d;
        wr(3'd0, 32'd2);
        check("R6 inverted idle level", {31'b0, pwm_out}, 32'd1);
        rd(3'd4, d); check("R8 status polarity", d, 32'd2);
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd0, 32'd3);
        measure(1'b1, hi, lo);
        check("R6 inverted active length", hi, 32'd6);
        check("R6 inverted inactive length", lo, 32'd10);
        wr(3'd0, 32'd2);
        check("R6 inverted stop level", {31'b0, pwm_out}, 32'd1);
        wr(3'd0, 32'd0);
        check("R6 normal idle level", {31'b0, pwm_out}, 32'd0);
    endtask

    task automatic t_prescale();
        int hi, lo;
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd0, 32'd13);   // run, prescaler on, exponent 1 -> ratio 4
        measure(1'b0, hi, lo);
        check("R9 prescaled active", hi, 32'd24);
        check("R9 prescaled inactive", lo, 32'd40);
        wr(3'd0, 32'd0);
    endtask

    task automatic t_min();
        int hi, lo;
        wr(3'd1, 32'hFFFF_FFFE);
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd0, 32'd1);
        measure(1'b0, hi, lo);
        check("R10 minimum active", hi, 32'd1);
        check("R10 minimum inactive", lo, 32'd1);
        wr(3'd0, 32'd0);
    endtask

    task automatic t_collision();
        int lows;
        lows = 0;
        wr(3'd1, 32'hFFFF_FFF0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd0, 32'd1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 50; i++) begin
            if (pwm_out != 1'b1) lows++;
            @(negedge clk);
        end
        check("R11 overflow wins over match", lows, 32'd0);
        wr(3'd0, 32'd0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_update();
        t_pol_locked();
        t_stop();
        t_invert();
        t_prescale();
        t_min();
        t_collision();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule